// File: doc/BRIEF.md
# Debug exception stop filter

This block sits beside a CPU's exception logic and decides, for each exception the core raises, whether the exception goes to the external debugger or to the normal software handler. The core presents a one-cycle strobe with a 4-bit exception code. A host-writable stop register holds one enable bit per exception kind. If the bit for the arriving kind is set, the exception is caught. On the next cycle the block pulses an ignore signal so the core drops the exception, raises the CPU stall, and records the cause in a sticky reason register.

The host reads and writes both registers through a small port. A write to the reason register replaces its contents, and this is how the host clears causes it has serviced. A debugger-disable input forces the stall output low without changing any recorded state.

Exception codes are fixed: 0 reset, 1 bus error, 2 data page fault, 3 instruction page fault, 4 tick timer, 5 alignment, 6 illegal instruction, 7 external interrupt, 8 data TLB miss, 9 instruction TLB miss, 10 range, 11 system call, 12 trap. Codes 13 to 15 name no kind. Stop bit n and reason bit n both belong to code n.

Top module: `dbg_exc_filter`

## Requirements
- R1: After reset the stop register and the reason register read 0, and exc_ignore and cpu_stall are 0.
- R2: A host write with host_sel=0 loads host_wdata into the stop register. A read with host_sel=0 returns the stop register and a read with host_sel=1 returns the reason register, in the same cycle.
- R3: If exc_valid is high and stop bit exc_code is set, exc_ignore is 1 in the following cycle and cpu_stall is 1 from the following cycle on.
- R4: If exc_valid is high and stop bit exc_code is clear, exc_ignore is 0 in the following cycle and cpu_stall is 0 from the following cycle on.
- R5: Codes 13, 14 and 15 are never ignored. They leave the reason register unchanged and deassert cpu_stall in the following cycle.
- R6: A caught exception sets reason bit exc_code. Reason bits that are already set stay set through later exceptions.
- R7: A host write with host_sel=1 replaces the reason register with host_wdata. If a capture happens in the same cycle, the captured bit ends up set.
- R8: exc_ignore lasts one cycle per caught strobe. Without a strobe, cpu_stall keeps its last decision.
- R9: While dbg_off is 1, cpu_stall is 0. dbg_off has no effect on exc_ignore or the reason register. When dbg_off returns to 0, a held stall decision shows again.
- R10: An exception decision uses the stop register value from before any host write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | One-cycle exception strobe |
| exc_code | input | 4 | Exception kind code |
| dbg_off | input | 1 | Debugger disable; forces stall low |
| host_wr_en | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects the stop register, 1 selects the reason register |
| host_wdata | input | 13 | Host write data |
| host_rdata | output | 13 | Selected register contents |
| exc_ignore | output | 1 | Core must drop this exception (one cycle) |
| cpu_stall | output | 1 | Stall request to the core |

## Verification
A wrong stop or reason bit is visible on host_rdata as soon as the host selects that register, and the reason register is compared after every cycle. A stop bit that is wrong also shows one cycle after the first strobe with that code, as a wrong exc_ignore and a wrong cpu_stall. A lost or spurious stall decision stays visible on cpu_stall until the next strobe, unless dbg_off hides it, so the reference model compares stall with dbg_off both low and high.

// File: rtl/dbg_exc_pkg.sv
package dbg_exc_pkg;
  localparam int unsigned KINDS  = 13;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET   = 4'd0,
    EXC_BUSERR  = 4'd1,
    EXC_DPAGE   = 4'd2,
    EXC_IPAGE   = 4'd3,
    EXC_TICK    = 4'd4,
    EXC_ALIGN   = 4'd5,
    EXC_ILLEGAL = 4'd6,
    EXC_EXTINT  = 4'd7,
    EXC_DTLB    = 4'd8,
    EXC_ITLB    = 4'd9,
    EXC_RANGE   = 4'd10,
    EXC_SYSCALL = 4'd11,
    EXC_TRAP    = 4'd12
  } exc_kind_e;
endpackage

// File: rtl/dbg_exc_decode.sv
module dbg_exc_decode #(
  parameter int unsigned KINDS  = dbg_exc_pkg::KINDS,
  parameter int unsigned CODE_W = dbg_exc_pkg::CODE_W
) (
  input  logic              strobe,
  input  logic [CODE_W-1:0] code,
  output logic [KINDS-1:0]  onehot
);
  // Codes at or above KINDS produce no bit, so they can never be caught.
  for (genvar g = 0; g < KINDS; g++) begin : g_kind
    assign onehot[g] = strobe && (code == CODE_W'(g));
  end
endmodule

// File: rtl/dbg_exc_regs.sv
module dbg_exc_regs #(
  parameter int unsigned KINDS = dbg_exc_pkg::KINDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr_en,
  input  logic             host_sel,
  input  logic [KINDS-1:0] host_wdata,
  input  logic [KINDS-1:0] capture,
  output logic [KINDS-1:0] stop_q,
  output logic [KINDS-1:0] reason_q,
  output logic [KINDS-1:0] host_rdata
);
  logic             stop_en, reason_en;
  logic [KINDS-1:0] stop_d, reason_d;

  always_comb begin
    stop_en   = host_wr_en && !host_sel;
    stop_d    = host_wdata;
    reason_en = (host_wr_en && host_sel) || (|capture);
    // A host write replaces the old contents, but a capture in the same cycle still sets its bit.
    reason_d  = ((host_wr_en && host_sel) ? host_wdata : reason_q) | capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q   <= '0;
      reason_q <= '0;
    end else begin
      if (stop_en)   stop_q   <= stop_d;
      if (reason_en) reason_q <= reason_d;
    end
  end

  assign host_rdata = host_sel ? reason_q : stop_q;
endmodule

// File: rtl/dbg_exc_decide.sv
module dbg_exc_decide #(
  parameter int unsigned KINDS = dbg_exc_pkg::KINDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_valid,
  input  logic [KINDS-1:0] capture,
  input  logic             dbg_off,
  output logic             exc_ignore,
  output logic             cpu_stall,
  output logic             stall_state
);
  logic hit;
  logic ignore_d, ignore_q;
  logic stall_d, stall_en;

  always_comb begin
    hit      = |capture;
    ignore_d = hit;
    stall_en = exc_valid;
    stall_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ignore_q    <= 1'b0;
      stall_state <= 1'b0;
    end else begin
      ignore_q <= ignore_d;
      if (stall_en) stall_state <= stall_d;
    end
  end

  assign exc_ignore = ignore_q;
  assign cpu_stall  = stall_state && !dbg_off;
endmodule

// File: rtl/dbg_exc_filter.sv
module dbg_exc_filter #(
  parameter int unsigned KINDS  = dbg_exc_pkg::KINDS,
  parameter int unsigned CODE_W = dbg_exc_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              dbg_off,
  input  logic              host_wr_en,
  input  logic              host_sel,
  input  logic [KINDS-1:0]  host_wdata,
  output logic [KINDS-1:0]  host_rdata,
  output logic              exc_ignore,
  output logic              cpu_stall
);
  logic [KINDS-1:0] kind_vec;
  logic [KINDS-1:0] capture;
  logic [KINDS-1:0] stop_q;
  logic [KINDS-1:0] reason_q;
  logic             stall_state;

  dbg_exc_decode #(.KINDS(KINDS), .CODE_W(CODE_W)) u_decode (
    .strobe (exc_valid),
    .code   (exc_code),
    .onehot (kind_vec)
  );

  assign capture = kind_vec & stop_q;

  dbg_exc_regs #(.KINDS(KINDS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr_en (host_wr_en),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .capture    (capture),
    .stop_q     (stop_q),
    .reason_q   (reason_q),
    .host_rdata (host_rdata)
  );

  dbg_exc_decide #(.KINDS(KINDS)) u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_valid   (exc_valid),
    .capture     (capture),
    .dbg_off     (dbg_off),
    .exc_ignore  (exc_ignore),
    .cpu_stall   (cpu_stall),
    .stall_state (stall_state)
  );
endmodule

// File: rtl/dbg_exc_filter_chk.sv
module dbg_exc_filter_chk #(
  parameter int unsigned KINDS  = dbg_exc_pkg::KINDS,
  parameter int unsigned CODE_W = dbg_exc_pkg::CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_valid,
  input logic [CODE_W-1:0] exc_code,
  input logic              dbg_off,
  input logic              host_wr_en,
  input logic              host_sel,
  input logic              exc_ignore,
  input logic              cpu_stall,
  input logic [KINDS-1:0]  reason_q,
  input logic              stall_state
);
  AST_IGNORE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ignore |-> $past(exc_valid)); // R8

  AST_UNKNOWN_CODE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(exc_valid) && ($past(exc_code) >= CODE_W'(KINDS))) |-> (!exc_ignore && !stall_state)); // R5

  AST_IGNORE_RECORDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ignore |-> (|(reason_q & (KINDS'(1) << $past(exc_code))))); // R6

  AST_REASON_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(host_wr_en) && $past(host_sel)) |-> ((reason_q & $past(reason_q)) == $past(reason_q))); // R6

  AST_STALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(exc_valid) |-> (stall_state == $past(stall_state))); // R8

  AST_STALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_off |-> !cpu_stall); // R9

  AST_STALL_MATCHES_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exc_valid) |-> (stall_state == exc_ignore)); // R3
endmodule

bind dbg_exc_filter dbg_exc_filter_chk #(.KINDS(KINDS), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .exc_valid   (exc_valid),
  .exc_code    (exc_code),
  .dbg_off     (dbg_off),
  .host_wr_en  (host_wr_en),
  .host_sel    (host_sel),
  .exc_ignore  (exc_ignore),
  .cpu_stall   (cpu_stall),
  .reason_q    (reason_q),
  .stall_state (stall_state)
);

// File: tb/dbg_exc_filter_bench.sv
module dbg_exc_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_valid;
  logic [3:0]  exc_code;
  logic        dbg_off;
  logic        host_wr_en;
  logic        host_sel;
  logic [12:0] host_wdata;
  logic [12:0] host_rdata;
  logic        exc_ignore;
  logic        cpu_stall;

  int compared = 0;
  int mismatched = 0;

  // Reference state, kept as plain integers
  int m_stop = 0, m_reason = 0, m_ign = 0, m_stall = 0;

  always #5 clk = ~clk;

  dbg_exc_filter u_dbg_exc_filter (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .dbg_off(dbg_off), .host_wr_en(host_wr_en), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .exc_ignore(exc_ignore), .cpu_stall(cpu_stall)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // The reference model advances on the rising edge, using the inputs held across it.
  always @(posedge clk) begin
    if (rst_n) begin
      int cap;
      cap = 0;
      if (exc_valid) begin
        if (exc_code < 13 && ((m_stop >> exc_code) & 1) != 0) cap = 1 << exc_code;
        m_ign   = (cap != 0) ? 1 : 0;
        m_stall = m_ign;
      end else begin
        m_ign = 0;
      end
      if (host_wr_en && host_sel) m_reason = int'(host_wdata) | cap;
      else                        m_reason = m_reason | cap;
      if (host_wr_en && !host_sel) m_stop = int'(host_wdata);
    end
  end

  task automatic compare_all(input string req);
    int exp_rd;
    exp_rd = host_sel ? m_reason : m_stop;
    chk(req, "ignore", int'(exc_ignore), m_ign);
    chk(req, "stall", int'(cpu_stall), (m_stall != 0 && !dbg_off) ? 1 : 0);
    chk(req, "rdata", int'(host_rdata), exp_rd);
  endtask

  // One cycle: drive on the falling edge, compare on the next falling edge.
  task automatic step(input logic v, input int code, input logic off, input logic wr,
                      input logic sel, input int wd, input string req);
    exc_valid  = v;
    exc_code   = 4'(code);
    dbg_off    = off;
    host_wr_en = wr;
    host_sel   = sel;
    host_wdata = 13'(wd);
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic read_back(input logic sel, input string req);
    step(1'b0, 0, 1'b0, 1'b0, sel, 0, req);
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    exc_valid = 0; exc_code = 0; dbg_off = 0; host_wr_en = 0; host_sel = 0; host_wdata = 0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    read_back(1'b0, "R1");
    read_back(1'b1, "R1");

    // R2: stop register write and readback
    step(0, 0, 0, 1, 0, 13'h1abc, "R2");
    read_back(1'b0, "R2");
    step(0, 0, 0, 1, 0, 13'h0892, "R2"); // bits 1,4,7,11 enabled

    // R3: caught bus error, then R8 pulse ends and stall holds
    step(1, 1, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 0, 1, 0, "R8");
    step(0, 0, 0, 0, 1, 0, "R8");
    // R4: disabled alignment code releases stall
    step(1, 5, 0, 0, 1, 0, "R4");
    // R6: more captures accumulate
    step(1, 7, 0, 0, 1, 0, "R6");
    step(1, 11, 0, 0, 1, 0, "R6");
    step(1, 6, 0, 0, 1, 0, "R6");
    // R5: unnamed codes
    step(1, 4, 0, 0, 1, 0, "R5");
    step(1, 13, 0, 0, 1, 0, "R5");
    step(1, 15, 0, 0, 1, 0, "R5");
    // R7: host clear collides with a capture
    step(1, 4, 0, 1, 1, 13'h0000, "R7");
    step(0, 0, 0, 1, 1, 13'h0003, "R7");
    // R9: debugger disable masks stall but not capture
    step(1, 7, 1, 0, 1, 0, "R9");
    step(0, 0, 1, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 1, 0, "R9");
    // R10: stop write and exception in the same cycle use the old stop value
    step(1, 12, 0, 1, 0, 13'h1000, "R10");
    step(1, 12, 0, 0, 0, 0, "R10");
    step(1, 4, 0, 1, 0, 13'h0000, "R10");

    // Mixed traffic
    for (int i = 0; i < 2000; i++) begin
      logic v, off, wr, sel;
      v   = ($urandom_range(0, 2) != 0);
      off = ($urandom_range(0, 5) == 0);
      wr  = ($urandom_range(0, 6) == 0);
      sel = $urandom_range(0, 1) != 0;
      step(v, $urandom_range(0, 15), off, wr, sel, $urandom_range(0, 8191), "R6");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule